// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a byte-wide flash device. Once software has issued a program or erase sequence, it pulses `start_i`. The block then finds out when the device has finished its internal operation. It issues read strobes on a simple synchronous bus, one strobe at a time, and read data returns one cycle after each strobe. It judges completion with one of three selectable methods. The first compares status bit 7 with the expected byte. The second compares bit 6 across two consecutive reads. The third watches a ready/busy level input.

Once completion is seen, the block performs one extra read and returns that byte as the final data, together with a one-cycle done pulse. If completion is not seen within a programmable number of evaluations, it reports a one-cycle timeout pulse instead. Polling can begin at once after the operation is issued, because the block needs no initial delay. Every read targets the address captured at start. For data polling, this is the address of the last byte loaded.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held and after it is released, `rd_o`, `busy_o`, `done_o` and `timeout_o` are low and `data_o` is zero.
- R2: Mode 2'b00 (bit-7 polling): a status read counts as complete when its bit 7 equals bit 7 of `expect_i`. A read whose bit 7 is the inverse of that bit counts as busy.
- R3: Mode 2'b01 (toggle): a read counts as complete when its bit 6 equals bit 6 of the previous read in the same run. The first read of a run is never complete.
- R4: Mode 2'b10 (ready/busy): `ready_i` is evaluated once per cycle while waiting, with high meaning complete. No status reads are issued in this mode.
- R5: Every strobe drives `rd_addr_o` with the `addr_i` value captured at start. Read data is taken from `rd_data_i` one cycle after the strobe.
- R6: `rd_o` is never high in two consecutive cycles.
- R7: After completion, exactly one further read is made. Its data appears on `data_o` while `done_o` is high for a single cycle.
- R8: If max(1, `max_polls_i`) evaluations are not complete, `timeout_o` pulses for one cycle and no further read is made. `data_o` then holds the last status read, or zero if no read was made.
- R9: `busy_o` rises in the cycle after an accepted start. A `start_i` pulse while `busy_o` is high is ignored, and the running mode, address and expected byte are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (accepted when idle) |
| mode_i | input | 2 | Detection method: 00 bit-7, 01 toggle, 10 ready/busy |
| addr_i | input | AW | Address to poll |
| expect_i | input | DW | Byte that was programmed |
| max_polls_i | input | CW | Evaluation limit before timeout (0 acts as 1) |
| ready_i | input | 1 | Ready/busy level from device, high = ready |
| rd_o | output | 1 | Read strobe |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | DW | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle timeout pulse |
| data_o | output | DW | Final data (or last status on timeout) |

## Verification
The bench emulates a device that returns a chosen number of busy status bytes, then true data, and compares every run with an independently computed outcome. It targets a completion on the very first evaluation. A design that demanded a prior read in bit-7 mode, or accepted the first read in toggle mode, would report the wrong strobe count. It targets a limit of zero and a limit reached exactly at the completing read; an off-by-one counter would either time out a finished operation or let an extra read through. It also targets toggle runs where the last busy status happens to share bit 6 with the true data, and starts pulsed mid-run. A design that restarted or switched modes on those starts would return the wrong data or flag.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    MODE_DATA   = 2'b00,
    MODE_TOGGLE = 2'b01,
    MODE_READY  = 2'b10,
    MODE_RSVD   = 2'b11
  } poll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CAP,
    ST_RDY,
    ST_FRD,
    ST_FCAP
  } poll_state_e;
endpackage

// File: rtl/poll_judge.sv
module poll_judge
  import flash_poll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  poll_mode_e        mode_i,
  input  logic [DW-1:0]     rd_data_i,
  input  logic [DW-1:0]     expect_i,
  input  logic              prev_valid_i,
  input  logic              prev_tog_i,
  input  logic              ready_i,
  output logic              complete_o
);
  always_comb begin
    unique case (mode_i)
      MODE_TOGGLE: complete_o = prev_valid_i && (rd_data_i[TOG_BIT] == prev_tog_i);
      MODE_READY:  complete_o = ready_i;
      default:     complete_o = (rd_data_i[POLL_BIT] == expect_i[POLL_BIT]);
    endcase
  end
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW:0] cnt_q;
  logic [CW:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;
  // limit 0 behaves as 1: the first failing step already hits
  assign hit_o   = step_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  input  logic [CW-1:0] max_polls_i,
  input  logic          ready_i,
  output logic          rd_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [DW-1:0] data_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  poll_state_e   state_q, state_d;
  poll_mode_e    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] expect_q;
  logic [CW-1:0] limit_q;
  logic [DW-1:0] data_q;
  logic          prev_tog_q, prev_valid_q;
  logic          done_q, tout_q;
  logic          accept, eval, complete, hit;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign eval   = (state_q == ST_CAP) || (state_q == ST_RDY);

  poll_judge #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_judge (
    .mode_i      (mode_q),
    .rd_data_i   (rd_data_i),
    .expect_i    (expect_q),
    .prev_valid_i(prev_valid_q),
    .prev_tog_i  (prev_tog_q),
    .ready_i     (ready_i),
    .complete_o  (complete)
  );

  poll_limit #(.CW(CW)) u_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .step_i (eval && !complete),
    .limit_i(limit_q),
    .hit_o  (hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (poll_mode_e'(mode_i) == MODE_READY) ? ST_RDY : ST_RD;
      ST_RD:   state_d = ST_CAP;
      ST_CAP:  state_d = complete ? ST_FRD : (hit ? ST_IDLE : ST_RD);
      ST_RDY:  state_d = complete ? ST_FRD : (hit ? ST_IDLE : ST_RDY);
      ST_FRD:  state_d = ST_FCAP;
      ST_FCAP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_DATA;
      addr_q       <= '0;
      expect_q     <= '0;
      limit_q      <= '0;
      data_q       <= '0;
      prev_tog_q   <= 1'b0;
      prev_valid_q <= 1'b0;
      done_q       <= 1'b0;
      tout_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FCAP);
      tout_q  <= eval && !complete && hit;
      if (accept) begin
        mode_q       <= poll_mode_e'(mode_i);
        addr_q       <= addr_i;
        expect_q     <= expect_i;
        limit_q      <= max_polls_i;
        data_q       <= '0;
        prev_valid_q <= 1'b0;
      end
      if (state_q == ST_CAP) begin
        data_q       <= rd_data_i;
        prev_tog_q   <= rd_data_i[TOG_BIT];
        prev_valid_q <= 1'b1;
      end
      if (state_q == ST_FCAP) data_q <= rd_data_i;
    end
  end

  assign rd_o      = (state_q == ST_RD) || (state_q == ST_FRD);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tout_q;
  assign data_o    = data_q;
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o
);
  AST_RD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o); // R6
  AST_NO_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_o); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_TOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R8
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9
endmodule

bind flash_done_poller flash_done_poller_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rd_o     (rd_o),
  .rd_addr_o(rd_addr_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o)
);

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] expect_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          ready_i;
  logic          rd_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, timeout_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // device model state
  int            cur_b = 0;
  logic [1:0]    cur_mode = 2'b00;
  logic [DW-1:0] cur_exp = '0;
  logic [AW-1:0] cur_addr = '0;
  int            rd_cnt = 0;
  int            busy_cnt = 0;
  int            addr_err = 0;

  flash_done_poller #(.AW(AW), .DW(DW), .CW(CW)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign ready_i = (busy_cnt >= cur_b);

  function automatic logic [7:0] dev_val(int k, int b, logic [7:0] e);
    if (k <= b) return {~e[7], k[0], e[5:0]};
    return e;
  endfunction

  always @(posedge clk_i) begin
    if (busy_o) busy_cnt <= busy_cnt + 1;
    if (rd_o) begin
      rd_cnt <= rd_cnt + 1;
      if (rd_addr_o != cur_addr) addr_err <= addr_err + 1;
      rd_data_i <= (cur_mode == 2'b10) ? cur_exp : dev_val(rd_cnt + 1, cur_b, cur_exp);
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected outcome from the requirements
  task automatic predict(input logic [1:0] m, input int b, input int maxp, input logic [7:0] e,
                         output logic ok, output logic [7:0] d, output int strobes);
    int me = (maxp == 0) ? 1 : maxp;
    ok = 1'b0; d = '0; strobes = 0;
    if (m == 2'b10) begin
      if (b + 1 <= me) begin ok = 1'b1; d = e; strobes = 1; end
    end else begin
      for (int j = 1; j <= me; j++) begin
        logic c;
        if (m == 2'b00) c = (dev_val(j, b, e)[7] == e[7]);
        else            c = (j >= 2) && (dev_val(j, b, e)[6] == dev_val(j - 1, b, e)[6]);
        if (c) begin ok = 1'b1; d = dev_val(j + 1, b, e); strobes = j + 1; return; end
      end
      d = dev_val(me, b, e);
      strobes = me;
    end
  endtask

  task automatic run(input logic [1:0] m, input int b, input int maxp, input logic [7:0] e,
                     input logic [AW-1:0] a, input bit inject);
    logic ok; logic [7:0] d; int s; int cyc;
    string tag;
    tag = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R4";
    predict(m, b, maxp, e, ok, d, s);
    @(negedge clk_i);
    cur_b = b; cur_mode = m; cur_exp = e; cur_addr = a;
    rd_cnt = 0; busy_cnt = 0; addr_err = 0;
    mode_i = m; expect_i = e; addr_i = a; max_polls_i = CW'(maxp);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R9 busy after start", busy_o, 1'b1);
    if (inject && busy_o) begin
      // R9: ignored start with conflicting settings
      mode_i = m + 2'd1; expect_i = ~e; addr_i = ~a; max_polls_i = '1;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!(done_o || timeout_o) && cyc < 2000) begin
      @(negedge clk_i);
      cyc++;
    end
    check({tag, " R7 done"}, done_o, ok);
    check("R8 timeout", timeout_o, !ok);
    check(ok ? "R7 final data" : "R8 last status", data_o, d);
    check({tag, " R4 strobe count"}, rd_cnt, s);
    check("R5 address", addr_err, 0);
    @(negedge clk_i);
    check("R7 R8 single pulse", {done_o, timeout_o}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1 rd", rd_o, 1'b0);
    check("R1 busy", busy_o, 1'b0);
    check("R1 flags", {done_o, timeout_o}, 2'b00);
    check("R1 data", data_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {rd_o, busy_o, done_o, timeout_o}, 4'b0000);

    // directed corners
    run(2'b00, 0, 4, 8'hA5, 20'h12345, 0); // R2 first read complete
    run(2'b01, 0, 4, 8'h3C, 20'h00002, 0); // R3 first read never complete
    run(2'b10, 0, 4, 8'h5A, 20'hFFFFF, 0); // R4 ready at once
    run(2'b00, 3, 0, 8'h81, 20'h00010, 0); // R8 limit zero
    run(2'b01, 3, 1, 8'h40, 20'h00011, 0); // R3 R8 toggle cannot finish in one
    run(2'b10, 5, 0, 8'h11, 20'h00012, 0); // R4 R8 no reads, data zero
    run(2'b00, 4, 5, 8'h7E, 20'h00013, 0); // R2 limit met exactly
    run(2'b00, 5, 5, 8'h7E, 20'h00014, 0); // R8 one short
    run(2'b01, 3, 8, 8'h40, 20'h00015, 0); // R3 last busy bit6 equals data bit6
    run(2'b01, 4, 8, 8'h40, 20'h00016, 0); // R3 needs two true reads
    run(2'b10, 6, 7, 8'hC3, 20'h00017, 0); // R4 limit met exactly
    run(2'b00, 6, 12, 8'h00, 20'h00018, 1); // R9 ignored start

    for (int i = 0; i < 60; i++) begin
      run(2'($urandom_range(0, 2)), int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
          8'($urandom), AW'($urandom), bit'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule